// File: doc/BRIEF.md
# Zero-overhead loop and breakpoint sequencer

This block works out the program counter of the next instruction word once the current word has finished. It reads the current PC and the outcome of any branch in that word. It also reads the hardware repeat-loop registers (loop start, loop end and a remaining-iteration count), the processor status word and a single breakpoint address. From these it picks one of four sources for the next PC: the sequential successor, the branch target, the loop start or the debug trap vector. Along with the PC it returns the updated loop count and the updated status word.

The PC counts in 32-bit instruction words, so the byte fetch address it drives is the next PC shifted left by two. The caller pulses `step_i` once per retired instruction word. One clock later the registered outputs hold the new PC, the new fetch address, the count and the status, and `trap_o` pulses when the breakpoint fired. Between steps the outputs keep their values.

The sources have a fixed priority. A breakpoint trap beats everything. A branch taken by the word beats the loop check. The loop check beats plain sequencing. A branch that lands on the loop-end address is legal: the word at that address executes first, and the loop check then applies when that word retires.

Top module: `zls_seq`

## Requirements
- R1: While `rst_i` is high and after it falls, until the first step, `next_pc_o` is RESET_PC (default 0xFFC0), `fetch_addr_o` is RESET_PC shifted left by two (0x3FF00), `count_o` and `status_o` are zero and `trap_o` is low.
- R2: A step with no branch, no loop hit and no breakpoint sets `next_pc_o` to `pc_i`+1, wrapping modulo 2^PC_W (0xFFFF goes to 0x0000), and passes count and status through unchanged.
- R3: A step with `br_taken_i` high and no breakpoint sets `next_pc_o` to `br_target_i`, even when `pc_i` equals `loop_end_i` with repeat enabled. Count and status pass through unchanged.
- R4: A step with repeat-enable (status bit RPT_BIT, default bit 1) set, `pc_i` equal to `loop_end_i`, no branch, no breakpoint and `loop_count_i` greater than 1 sets `next_pc_o` to `loop_start_i` and `count_o` to `loop_count_i`-1. Status is unchanged. This holds however `pc_i` was reached, including by a branch onto the loop-end address.
- R5: Under the same conditions as R4 but with `loop_count_i` of 1 or 0 (the last iteration), the step sets `next_pc_o` to `pc_i`+1, sets `count_o` to 0 and clears the repeat-enable bit in `status_o`. All other status bits are unchanged.
- R6: With the repeat-enable bit clear, a step at `pc_i` equal to `loop_end_i` behaves as R2.
- R7: A step with debug-enable (status bit DBG_BIT, default bit 14) set and `pc_i` equal to `bp_addr_i` sets `next_pc_o` to TRAP_VEC (default 0x3FF0). It clears every status bit except the stack-mode bit (SM_BIT, default bit 15), leaves the count as `loop_count_i` and raises `trap_o` for exactly one cycle. This overrides a taken branch and a loop hit.
- R8: With the debug-enable bit clear, a PC equal to `bp_addr_i` causes no trap; the step follows R2 to R6.
- R9: `fetch_addr_o` always equals `next_pc_o` shifted left by two, with its two low bits zero.
- R10: In a cycle where `step_i` is low, on the next edge the outputs keep their values and `trap_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One instruction word retired; evaluate the inputs |
| pc_i | input | PC_W | Word address of the retired instruction word |
| br_taken_i | input | 1 | The retired word took a branch |
| br_target_i | input | PC_W | Word address of the branch target |
| loop_start_i | input | PC_W | First word of the repeat loop |
| loop_end_i | input | PC_W | Last word of the repeat loop |
| loop_count_i | input | CNT_W | Remaining iterations of the repeat loop |
| status_i | input | STAT_W | Current status word |
| bp_addr_i | input | PC_W | Breakpoint word address |
| next_pc_o | output | PC_W | Word address of the next instruction word |
| fetch_addr_o | output | PC_W+2 | Byte fetch address, next PC shifted left by two |
| count_o | output | CNT_W | Updated loop count |
| status_o | output | STAT_W | Updated status word |
| trap_o | output | 1 | One-cycle pulse when the breakpoint trap fired |

## Verification
The assertions sample the inputs only in the cycle where `step_i` is high, and they take the inputs to be stable and known in that cycle. They also take the caller to hold `step_i` low during reset and not to need the outputs until a step has retired. The property for each source checks only the input combinations in which that source has the highest priority. The bench drives every input at the falling edge together with a one-cycle step, then drops the step. It reads the outputs at the next falling edge, so each vector sits squarely inside those assumptions. Loop start, loop end and breakpoint are kept distinct except where a vector sets out to make them coincide.

// File: rtl/zls_pkg.sv
package zls_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_LOOP   = 2'd2,
    SRC_TRAP   = 2'd3
  } pc_src_e;
endpackage

// File: rtl/zls_loop_eval.sv
module zls_loop_eval #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  loop_end_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rpt_en_i,
  input  logic             branch_i,
  output logic             loop_back_o,
  output logic             last_iter_o,
  output logic [CNT_W-1:0] count_nxt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_end;
  logic more;

  // the loop check only applies when the word itself did not redirect
  assign at_end      = rpt_en_i && (pc_i == loop_end_i) && !branch_i;
  assign more        = (count_i > ONE);
  assign loop_back_o = at_end && more;
  assign last_iter_o = at_end && !more;

  always_comb begin
    count_nxt_o = count_i;
    if (loop_back_o)      count_nxt_o = count_i - ONE;
    else if (last_iter_o) count_nxt_o = '0;
  end
endmodule

// File: rtl/zls_bp_match.sv
module zls_bp_match #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] bp_addr_i,
  input  logic            dbg_en_i,
  output logic            hit_o
);
  logic [PC_W-1:0] diff;

  genvar gi;
  generate
    for (gi = 0; gi < PC_W; gi++) begin : g_cmp
      assign diff[gi] = pc_i[gi] ^ bp_addr_i[gi];
    end
  endgenerate

  assign hit_o = dbg_en_i && (diff == '0);
endmodule

// File: rtl/zls_pc_select.sv
module zls_pc_select
  import zls_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'h3FF0
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  input  logic [PC_W-1:0] loop_start_i,
  input  logic            loop_back_i,
  input  logic            trap_i,
  output pc_src_e         src_o,
  output logic [PC_W-1:0] pc_nxt_o
);
  always_comb begin
    if (trap_i)           src_o = SRC_TRAP;
    else if (br_taken_i)  src_o = SRC_BRANCH;
    else if (loop_back_i) src_o = SRC_LOOP;
    else                  src_o = SRC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      SRC_TRAP:   pc_nxt_o = TRAP_VEC;
      SRC_BRANCH: pc_nxt_o = br_target_i;
      SRC_LOOP:   pc_nxt_o = loop_start_i;
      default:    pc_nxt_o = pc_i + PC_W'(1);
    endcase
  end
endmodule

// File: rtl/zls_seq.sv
module zls_seq
  import zls_pkg::*;
#(
  parameter int                PC_W     = 16,
  parameter int                CNT_W    = 16,
  parameter int                STAT_W   = 16,
  parameter int                RPT_BIT  = 1,
  parameter int                DBG_BIT  = 14,
  parameter int                SM_BIT   = 15,
  parameter logic [PC_W-1:0]   RESET_PC = 16'hFFC0,
  parameter logic [PC_W-1:0]   TRAP_VEC = 16'h3FF0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              br_taken_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic [PC_W-1:0]   loop_start_i,
  input  logic [PC_W-1:0]   loop_end_i,
  input  logic [CNT_W-1:0]  loop_count_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [PC_W-1:0]   bp_addr_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [PC_W+1:0]   fetch_addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o
);
  localparam int              FA_W     = PC_W + 2;
  localparam logic [STAT_W-1:0] SM_MASK  = STAT_W'(1) << SM_BIT;
  localparam logic [STAT_W-1:0] RPT_MASK = STAT_W'(1) << RPT_BIT;

  logic              loop_back, last_iter, bp_hit;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [PC_W-1:0]   pc_nxt;
  logic [STAT_W-1:0] st_nxt;
  pc_src_e           src;

  zls_loop_eval #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
    .pc_i        (pc_i),
    .loop_end_i  (loop_end_i),
    .count_i     (loop_count_i),
    .rpt_en_i    (status_i[RPT_BIT]),
    .branch_i    (br_taken_i),
    .loop_back_o (loop_back),
    .last_iter_o (last_iter),
    .count_nxt_o (cnt_nxt)
  );

  zls_bp_match #(.PC_W(PC_W)) u_bp (
    .pc_i      (pc_i),
    .bp_addr_i (bp_addr_i),
    .dbg_en_i  (status_i[DBG_BIT]),
    .hit_o     (bp_hit)
  );

  zls_pc_select #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_sel (
    .pc_i         (pc_i),
    .br_taken_i   (br_taken_i),
    .br_target_i  (br_target_i),
    .loop_start_i (loop_start_i),
    .loop_back_i  (loop_back),
    .trap_i       (bp_hit),
    .src_o        (src),
    .pc_nxt_o     (pc_nxt)
  );

  always_comb begin
    st_nxt = status_i;
    if (src == SRC_TRAP)   st_nxt = status_i & SM_MASK;
    else if (last_iter)    st_nxt = status_i & ~RPT_MASK;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      next_pc_o    <= RESET_PC;
      fetch_addr_o <= {RESET_PC, 2'b00};
      count_o      <= '0;
      status_o     <= '0;
      trap_o       <= 1'b0;
    end else begin
      trap_o <= step_i && bp_hit;
      if (step_i) begin
        next_pc_o    <= pc_nxt;
        fetch_addr_o <= FA_W'({pc_nxt, 2'b00});
        count_o      <= (src == SRC_TRAP) ? loop_count_i : cnt_nxt;
        status_o     <= st_nxt;
      end
    end
  end

  // ---------------- assertions ----------------
  p_seq_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !br_taken_i && !(status_i[DBG_BIT] && pc_i == bp_addr_i)
       && !(status_i[RPT_BIT] && pc_i == loop_end_i))
    |=> (next_pc_o == $past(pc_i) + PC_W'(1)) && (count_o == $past(loop_count_i)));

  p_branch_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && br_taken_i && !(status_i[DBG_BIT] && pc_i == bp_addr_i))
    |=> (next_pc_o == $past(br_target_i)) && (status_o == $past(status_i)));

  p_loop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !br_taken_i && status_i[RPT_BIT] && pc_i == loop_end_i
       && loop_count_i > CNT_W'(1) && !(status_i[DBG_BIT] && pc_i == bp_addr_i))
    |=> (next_pc_o == $past(loop_start_i)) && (count_o == $past(loop_count_i) - CNT_W'(1)));

  p_last_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !br_taken_i && status_i[RPT_BIT] && pc_i == loop_end_i
       && loop_count_i <= CNT_W'(1) && !(status_i[DBG_BIT] && pc_i == bp_addr_i))
    |=> !status_o[RPT_BIT] && (count_o == '0) && (next_pc_o == $past(pc_i) + PC_W'(1)));

  p_trap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_o |-> (next_pc_o == TRAP_VEC) && ((status_o & ~SM_MASK) == '0));

  p_nodbg_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !status_i[DBG_BIT] |=> !trap_o);

  p_fetch_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_addr_o[1:0] == 2'b00) && (fetch_addr_o[FA_W-1:2] == next_pc_o));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(next_pc_o) && $stable(count_o) && $stable(status_o) && !trap_o);
endmodule

// File: tb/zls_seq_bench.sv
module zls_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        step;
  logic [15:0] pc, tgt, lstart, lend, cnt, st, bp;
  logic        br;
  logic [15:0] npc, cnt_o, st_o;
  logic [17:0] fa;
  logic        trap;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zls_seq u_zls_seq (
    .clk_i(clk), .rst_i(rst), .step_i(step), .pc_i(pc), .br_taken_i(br),
    .br_target_i(tgt), .loop_start_i(lstart), .loop_end_i(lend),
    .loop_count_i(cnt), .status_i(st), .bp_addr_i(bp),
    .next_pc_o(npc), .fetch_addr_o(fa), .count_o(cnt_o), .status_o(st_o),
    .trap_o(trap)
  );

  // status bits: stack mode 15, debug enable 14, repeat enable 1
  localparam logic [15:0] SM  = 16'h8000;
  localparam logic [15:0] DBG = 16'h4000;
  localparam logic [15:0] RPT = 16'h0002;
  localparam logic [15:0] TV  = 16'h3FF0;

  typedef struct packed {
    logic [15:0] pc;  logic br; logic [15:0] tgt; logic [15:0] bp;
    logic [15:0] cnt; logic [15:0] st;
    logic [15:0] e_pc; logic [15:0] e_cnt; logic [15:0] e_st; logic e_trap;
  } vec_t;

  localparam int NV = 12;
  // loop start 0x0100, loop end 0x0110 throughout the table
  localparam vec_t VECS [NV] = '{
    '{16'h0050, 1'b0, 16'h0000, 16'h0200, 16'd5, 16'h0000,     16'h0051, 16'd5, 16'h0000,     1'b0},
    '{16'h0110, 1'b0, 16'h0000, 16'h0200, 16'd5, RPT,          16'h0100, 16'd4, RPT,          1'b0},
    '{16'h0110, 1'b0, 16'h0000, 16'h0200, 16'd1, RPT|16'h0010, 16'h0111, 16'd0, 16'h0010,     1'b0},
    '{16'h0110, 1'b0, 16'h0000, 16'h0200, 16'd0, RPT,          16'h0111, 16'd0, 16'h0000,     1'b0},
    '{16'h0110, 1'b1, 16'h0300, 16'h0200, 16'd5, RPT,          16'h0300, 16'd5, RPT,          1'b0},
    '{16'h0110, 1'b0, 16'h0000, 16'h0200, 16'd5, 16'h0000,     16'h0111, 16'd5, 16'h0000,     1'b0},
    '{16'h0200, 1'b1, 16'h0300, 16'h0200, 16'd5, DBG|SM|RPT|16'h0010, TV, 16'd5, SM,          1'b1},
    '{16'h0110, 1'b0, 16'h0000, 16'h0110, 16'd5, DBG|RPT,      TV,       16'd5, 16'h0000,     1'b1},
    '{16'h0200, 1'b0, 16'h0000, 16'h0200, 16'd5, RPT|16'h0010, 16'h0201, 16'd5, RPT|16'h0010, 1'b0},
    '{16'hFFFF, 1'b0, 16'h0000, 16'h0200, 16'd7, 16'h0000,     16'h0000, 16'd7, 16'h0000,     1'b0},
    '{16'h0050, 1'b1, 16'h0110, 16'h0200, 16'd3, RPT,          16'h0110, 16'd3, RPT,          1'b0},
    '{16'h0110, 1'b0, 16'h0000, 16'h0200, 16'd3, RPT,          16'h0100, 16'd2, RPT,          1'b0}
  };
  localparam string TAGS [NV] = '{"R2", "R4", "R5", "R5", "R3", "R6",
                                  "R7", "R7", "R8", "R2", "R3", "R4"};

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    pc = v.pc; br = v.br; tgt = v.tgt; bp = v.bp; cnt = v.cnt; st = v.st;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; step = 1'b0; br = 1'b0; pc = '0; tgt = '0;
    lstart = 16'h0100; lend = 16'h0110; cnt = '0; st = '0; bp = 16'h0200;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "next_pc", npc, 16'hFFC0);
    check("R1", "fetch", fa, 18'h3FF00);
    check("R1", "count", cnt_o, 0);
    check("R1", "status", st_o, 0);
    check("R1", "trap", trap, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "next_pc after release", npc, 16'hFFC0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check(TAGS[i], $sformatf("v%0d next_pc", i), npc, VECS[i].e_pc);
      check(TAGS[i], $sformatf("v%0d count", i), cnt_o, VECS[i].e_cnt);
      check(TAGS[i], $sformatf("v%0d status", i), st_o, VECS[i].e_st);
      check(TAGS[i], $sformatf("v%0d trap", i), trap, VECS[i].e_trap);
      check("R9", $sformatf("v%0d fetch", i), fa, {VECS[i].e_pc, 2'b00});
    end

    // R7 trap pulse lasts one cycle; R10 outputs hold with step low
    apply(VECS[6]);
    check("R7", "trap pulse", trap, 1);
    pc = 16'h0200; st = DBG; br = 1'b1; tgt = 16'h0777;
    @(negedge clk);
    check("R10", "trap low when idle", trap, 0);
    check("R10", "next_pc held", npc, TV);
    check("R10", "status held", st_o, SM);
    check("R10", "count held", cnt_o, 5);

    // R1: reset mid-run returns to reset state
    rst = 1'b1;
    @(negedge clk);
    check("R1", "next_pc mid-run reset", npc, 16'hFFC0);
    check("R1", "status mid-run reset", st_o, 0);
    rst = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule